// File: doc/BRIEF.md
# Switch Port-Tag Inserter and Stripper

This block sits between a host Ethernet MAC and the CPU-facing port of a managed switch, and it speaks a 2-byte management tag on both paths. Both sides use byte streams with valid/ready handshakes and start/end markers. On the transmit path, every frame heading into the switch gets a tag spliced in directly after its two 6-byte MAC addresses, ahead of the EtherType. The tag names the egress port that the host chose, which arrives as a sideband index with the first byte of the frame.

On the receive path, the block takes the tag out of frames that arrive from the switch, checks it, and reports which switch port the frame came in on as a host-side index. The 12 address bytes and the 2 tag bytes are held inside the block until the tag has been judged. A frame with a bad tag, or one that ends before the tag is complete, produces no output at all. Frames that pass the check are replayed with the tag removed, and the rest of the frame then streams straight through.

Top module: `switch_tag_codec`

## Requirements
- R1: On transmit, exactly two tag bytes are emitted after the 12th byte of a frame. All input bytes pass through unchanged and in order.
- R2: The first (most significant) transmit tag byte is 0x80: version 2 in tag bits [15:14], with priority and control zero. The second byte is 0x80 (the from-host bit 7) OR 1<<(n+1), where n is the port index sampled with the first byte of the frame, for n in 0..4.
- R3: While the transmitter emits the tag, it holds tx_in_ready low for exactly two cycles. Otherwise, with tx_out_ready high, it moves one byte per cycle. The start marker goes out on the first output byte and the end marker on the last.
- R4: A transmit frame that ends within its first 12 bytes passes through with no tag added.
- R5: On receive, a valid frame comes out without its bytes 12 and 13. Every other byte appears in order, with rx_out_sof on the first output byte and rx_out_eof on the last.
- R6: The low 3 bits of the second received tag byte give the source port p. For p in 1..6, rx_out_port shows p-1 for the whole output frame.
- R7: A received frame whose tag version bits (bits 7:6 of its 13th byte) are not binary 10 is dropped whole, with no output byte.
- R8: A received frame whose source field is 0 or 7 is dropped whole.
- R9: A received frame of 13 bytes or fewer is dropped whole. A 14-byte frame comes out as its 12 address bytes, with the end marker on the 12th byte.
- R10: While a receive output byte is stalled by rx_out_ready low during the address replay, it holds steady. Any rx_out_port value shown with a start marker lies in 0..5.
- R11: The received priority, type and tagged-frame bits (tag bits 13:3 other than the version) have no effect on the output data or port.
- R12: After reset, both output valids are low and rx_in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | Host transmit byte valid |
| tx_in_ready | output | 1 | Host transmit byte accepted |
| tx_in_data | input | 8 | Host transmit byte |
| tx_in_sof | input | 1 | First byte of transmit frame |
| tx_in_eof | input | 1 | Last byte of transmit frame |
| tx_in_port | input | 3 | Egress port index, sampled with the first byte |
| tx_out_valid | output | 1 | Tagged byte valid toward switch |
| tx_out_ready | input | 1 | Switch accepts tagged byte |
| tx_out_data | output | 8 | Tagged byte |
| tx_out_sof | output | 1 | First tagged byte |
| tx_out_eof | output | 1 | Last tagged byte |
| rx_in_valid | input | 1 | Tagged byte valid from switch |
| rx_in_ready | output | 1 | Tagged byte accepted |
| rx_in_data | input | 8 | Tagged byte from switch |
| rx_in_sof | input | 1 | First tagged byte |
| rx_in_eof | input | 1 | Last tagged byte |
| rx_out_valid | output | 1 | Untagged byte valid toward host |
| rx_out_ready | input | 1 | Host accepts untagged byte |
| rx_out_data | output | 8 | Untagged byte |
| rx_out_sof | output | 1 | First untagged byte |
| rx_out_eof | output | 1 | Last untagged byte |
| rx_out_port | output | 3 | Source port index of current receive frame |

## Verification
On transmit, the bench sends frames for the lowest and highest port indices, with the sink both always ready and toggling. This separates the bitmap shift and the stall count from the effect of backpressure. A frame shorter than the address field shows that no tag is added to it. On receive, the good frames differ in source port, in the extra tag bits and in payload length (down to zero). Each bad frame breaks exactly one condition (version, source 0, source 7, too short), so every drop path is exercised alone. A good frame sent after a drop shows that the block recovers.

// File: rtl/switch_tag_codec.sv
module switch_tag_codec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_sof,
  input  logic       tx_in_eof,
  input  logic [2:0] tx_in_port,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  output logic [7:0] tx_out_data,
  output logic       tx_out_sof,
  output logic       tx_out_eof,
  input  logic       rx_in_valid,
  output logic       rx_in_ready,
  input  logic [7:0] rx_in_data,
  input  logic       rx_in_sof,
  input  logic       rx_in_eof,
  output logic       rx_out_valid,
  input  logic       rx_out_ready,
  output logic [7:0] rx_out_data,
  output logic       rx_out_sof,
  output logic       rx_out_eof,
  output logic [2:0] rx_out_port
);
  localparam int ADDR_BYTES = 12;

  // transmit: position 0..11 address, 12..13 tag, 14 body
  logic [3:0] tx_pos;
  logic [2:0] tx_port_q;
  logic [6:0] tx_map;
  logic       tx_tag;

  assign tx_tag       = (tx_pos == 4'd12) || (tx_pos == 4'd13);
  assign tx_map       = (tx_port_q <= 3'd4) ? 7'(7'd1 << (tx_port_q + 3'd1)) : 7'd0;
  assign tx_out_valid = tx_tag || tx_in_valid;
  assign tx_out_data  = (tx_pos == 4'd12) ? 8'h80 :
                        (tx_pos == 4'd13) ? {1'b1, tx_map} : tx_in_data;
  assign tx_out_sof   = !tx_tag && tx_in_sof;
  assign tx_out_eof   = !tx_tag && tx_in_eof;
  assign tx_in_ready  = !tx_tag && tx_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pos    <= '0;
      tx_port_q <= '0;
    end else if (tx_out_valid && tx_out_ready) begin
      if (tx_tag)
        tx_pos <= tx_pos + 4'd1;
      else begin
        if (tx_pos == 4'd0) tx_port_q <= tx_in_port;
        if (tx_in_eof)             tx_pos <= '0;
        else if (tx_pos != 4'd14)  tx_pos <= tx_pos + 4'd1;
      end
    end
  end

  // receive
  typedef enum logic [1:0] {COLLECT, REPLAY, PASS, DISCARD} rx_state_t;
  rx_state_t  rx_st;
  logic [3:0] rx_cnt;
  logic [7:0] rx_hi;
  logic       rx_last;
  logic [7:0] mac_q [ADDR_BYTES];
  logic       rx_take, rx_good;

  assign rx_good     = (rx_hi[7:6] == 2'b10) && (rx_in_data[2:0] != 3'd0) &&
                       (rx_in_data[2:0] != 3'd7);
  assign rx_in_ready = (rx_st == COLLECT) || (rx_st == DISCARD) ||
                       ((rx_st == PASS) && rx_out_ready);
  assign rx_take     = rx_in_valid && rx_in_ready;

  assign rx_out_valid = (rx_st == REPLAY) || ((rx_st == PASS) && rx_in_valid);
  assign rx_out_data  = (rx_st == REPLAY) ? mac_q[rx_cnt] : rx_in_data;
  assign rx_out_sof   = (rx_st == REPLAY) && (rx_cnt == 4'd0);
  assign rx_out_eof   = (rx_st == REPLAY) ? (rx_last && rx_cnt == 4'd11) :
                        ((rx_st == PASS) && rx_in_eof);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st       <= COLLECT;
      rx_cnt      <= '0;
      rx_hi       <= '0;
      rx_last     <= 1'b0;
      rx_out_port <= '0;
      for (int i = 0; i < ADDR_BYTES; i++) mac_q[i] <= '0;
    end else begin
      unique case (rx_st)
        COLLECT: if (rx_take) begin
          if (rx_cnt < 4'd12) mac_q[rx_cnt] <= rx_in_data;
          if (rx_cnt == 4'd12) rx_hi <= rx_in_data;
          if (rx_cnt == 4'd13) begin
            rx_cnt <= '0;
            if (rx_good) begin
              rx_st       <= REPLAY;
              rx_last     <= rx_in_eof;
              rx_out_port <= rx_in_data[2:0] - 3'd1;
            end else if (!rx_in_eof)
              rx_st <= DISCARD;
          end else if (rx_in_eof)
            rx_cnt <= '0;
          else
            rx_cnt <= rx_cnt + 4'd1;
        end
        REPLAY: if (rx_out_ready) begin
          if (rx_cnt == 4'd11) begin
            rx_cnt <= '0;
            rx_st  <= rx_last ? COLLECT : PASS;
          end else
            rx_cnt <= rx_cnt + 4'd1;
        end
        PASS:    if (rx_take && rx_in_eof) rx_st <= COLLECT;
        DISCARD: if (rx_take && rx_in_eof) rx_st <= COLLECT;
        default: rx_st <= COLLECT;
      endcase
    end
  end
endmodule

module switch_tag_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_in_sof,
  input logic       tx_in_ready,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic       tx_out_sof,
  input logic       rx_in_ready,
  input logic       rx_out_valid,
  input logic       rx_out_ready,
  input logic       rx_out_sof,
  input logic [7:0] rx_out_data,
  input logic [2:0] rx_out_port
);
  assert_tx_sof_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && tx_out_sof |-> tx_in_sof && tx_in_ready == tx_out_ready);

  assert_rx_replay_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready && !rx_in_ready |=> rx_out_valid && $stable(rx_out_data));

  assert_rx_port_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_out_sof |-> rx_out_port <= 3'd5);

  assert_rx_sof_stalls_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_out_sof |-> !rx_in_ready);

  assert_tx_tag_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_in_ready && tx_out_ready |-> tx_out_valid && !tx_out_sof);
endmodule

bind switch_tag_codec switch_tag_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_in_sof(tx_in_sof), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_sof(tx_out_sof),
  .rx_in_ready(rx_in_ready), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_out_sof(rx_out_sof), .rx_out_data(rx_out_data), .rx_out_port(rx_out_port)
);

// File: tb/test_switch_tag_codec.sv
module test_switch_tag_codec;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic       tx_in_valid = 0, tx_in_sof = 0, tx_in_eof = 0, tx_in_ready;
  logic [7:0] tx_in_data = 0;
  logic [2:0] tx_in_port = 0;
  logic       tx_out_valid, tx_out_sof, tx_out_eof;
  logic       tx_out_ready = 1;
  logic [7:0] tx_out_data;
  logic       rx_in_valid = 0, rx_in_sof = 0, rx_in_eof = 0, rx_in_ready;
  logic [7:0] rx_in_data = 0;
  logic       rx_out_valid, rx_out_sof, rx_out_eof;
  logic       rx_out_ready = 1;
  logic [7:0] rx_out_data;
  logic [2:0] rx_out_port;

  switch_tag_codec i_switch_tag_codec (.*);

  int checks = 0, errors = 0, cyc = 0, stalls = 0;
  bit bp = 0, done = 0;
  logic [7:0] frame[$], expq[$], got[$];
  int sof_at[$], eof_at[$];
  logic [2:0] port_sof, port_eof;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_out_ready <= bp ? cyc[0] : 1'b1;
    rx_out_ready <= bp ? cyc[0] : 1'b1;
  end

  initial forever begin
    @(negedge clk); #4;
    if (tx_in_valid && !tx_in_ready && tx_out_ready) stalls++;
    if (tx_out_valid && tx_out_ready) begin
      if (tx_out_sof) sof_at.push_back(got.size());
      if (tx_out_eof) eof_at.push_back(got.size());
      got.push_back(tx_out_data);
    end
    if (rx_out_valid && rx_out_ready) begin
      if (rx_out_sof) begin sof_at.push_back(got.size()); port_sof = rx_out_port; end
      if (rx_out_eof) begin eof_at.push_back(got.size()); port_eof = rx_out_port; end
      got.push_back(rx_out_data);
    end
  end

  task automatic clear();
    got.delete(); sof_at.delete(); eof_at.delete(); expq.delete(); stalls = 0;
  endtask

  task automatic make(input int n, input int seed);
    frame.delete();
    for (int i = 0; i < n; i++) frame.push_back(8'(seed + i * 7));
  endtask

  task automatic send(input bit to_rx, input logic [2:0] port);
    for (int i = 0; i < frame.size(); i++) begin
      @(negedge clk);
      if (to_rx) begin
        rx_in_valid = 1; rx_in_data = frame[i];
        rx_in_sof = (i == 0); rx_in_eof = (i == frame.size() - 1);
        #4; while (!rx_in_ready) begin @(negedge clk); #4; end
      end else begin
        tx_in_valid = 1; tx_in_data = frame[i]; tx_in_port = (i == 0) ? port : 3'd0;
        tx_in_sof = (i == 0); tx_in_eof = (i == frame.size() - 1);
        #4; while (!tx_in_ready) begin @(negedge clk); #4; end
      end
      @(posedge clk);
    end
    @(negedge clk);
    tx_in_valid = 0; rx_in_valid = 0; tx_in_sof = 0; tx_in_eof = 0; rx_in_sof = 0; rx_in_eof = 0;
    repeat (40) @(negedge clk);
  endtask

  task automatic compare(input string req);
    bit same = (got.size() == expq.size());
    chk(same, req, "length", got.size(), expq.size());
    for (int i = 0; same && i < got.size(); i++)
      if (got[i] !== expq[i]) begin
        chk(0, req, $sformatf("byte %0d", i), got[i], expq[i]);
        same = 0;
      end
    if (expq.size() > 0) begin
      chk(sof_at.size() == 1 && sof_at[0] == 0, req, "sof position", sof_at.size() ? sof_at[0] : -1, 0);
      chk(eof_at.size() == 1 && eof_at[0] == expq.size() - 1, req, "eof position",
          eof_at.size() ? eof_at[0] : -1, expq.size() - 1);
    end
  endtask

  task automatic tx_case(input string req, input int n, input logic [2:0] port, input bit pressure);
    clear(); bp = pressure; make(n, 16 + n);
    for (int i = 0; i < n; i++) begin
      expq.push_back(frame[i]);
      if (i == 11 && n > 12) begin
        expq.push_back(8'h80);
        expq.push_back(8'h80 | 8'(1 << (port + 1)));
      end
    end
    send(0, port);
    compare(req);
    if (n > 12 && !pressure) chk(stalls == 2, "R3", "input stall cycles", stalls, 2);
    if (n <= 12) chk(stalls == 0, "R4", "input stall cycles", stalls, 0);
    bp = 0;
  endtask

  task automatic rx_case(input string req, input int n, input logic [7:0] hi, input logic [7:0] lo,
                         input bit pressure, input bit good);
    clear(); bp = pressure; make(n, 40 + n);
    if (n > 12) frame[12] = hi;
    if (n > 13) frame[13] = lo;
    if (good) for (int i = 0; i < n; i++) if (i != 12 && i != 13) expq.push_back(frame[i]);
    send(1, 3'd0);
    compare(req);
    if (good) begin
      chk(port_sof == 3'(lo[2:0] - 1), "R6", "port at sof", port_sof, lo[2:0] - 1);
      chk(port_eof == port_sof, "R6", "port held at eof", port_eof, port_sof);
    end
    bp = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(0, "watchdog", "timeout", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_out_valid == 0, "R12", "tx_out_valid after reset", tx_out_valid, 0);
    chk(rx_out_valid == 0, "R12", "rx_out_valid after reset", rx_out_valid, 0);
    chk(rx_in_ready == 1, "R12", "rx_in_ready after reset", rx_in_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    tx_case("R1 R2 port0", 20, 3'd0, 0);
    tx_case("R2 port4 backpressure", 18, 3'd4, 1);
    tx_case("R2 port2", 14, 3'd2, 0);
    tx_case("R4 short", 8, 3'd1, 0);

    rx_case("R5 src3", 22, 8'h80, 8'h03, 0, 1);
    rx_case("R11 R10 src6 extra bits backpressure", 20, 8'hB8, 8'hCE, 1, 1);
    rx_case("R7 version", 20, 8'h40, 8'h02, 0, 0);
    rx_case("R7 recovery", 16, 8'h80, 8'h01, 0, 1);
    rx_case("R8 src0", 20, 8'h80, 8'h00, 0, 0);
    rx_case("R8 src7", 20, 8'h80, 8'h07, 0, 0);
    rx_case("R9 short13", 13, 8'h80, 8'h02, 0, 0);
    rx_case("R9 exact14", 14, 8'h80, 8'h05, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule